// File: doc/BRIEF.md
# Variable-Dwell Multi-Cycle Stage Sequencer

This block is the timing controller of a multi-cycle processor. It walks one instruction at a time through five stages: fetch, decode, execute, data memory and write-back. The sequencer runs on a fast base clock, and each stage occupies its own parameterised number of base ticks, so a short stage is never padded out to the length of the longest one. Stages that an instruction class does not need are skipped, so the latency of an instruction is the sum of the stages it actually visits.

The surrounding datapath samples a one-hot stage indicator and latches its per-stage results on a stage-enable pulse. The pulse comes once per stage, on that stage's closing tick. A done strobe marks the end of each instruction. A tick counter reports how many base ticks the current instruction has used, and it keeps the last total while the block is idle. A start strobe launches the next instruction. If start is held on the done tick, the next fetch follows with no idle gap. Instructions never overlap.

Top module: `mc_stage_seq`

## Requirements
- R1: `stageOneHot` has at most one bit set. Bit 0 is fetch, bit 1 decode, bit 2 execute, bit 3 data memory and bit 4 write-back. The stages visited always appear in that ascending order, and the value is zero while idle.
- R2: Each visited stage lasts exactly its parameter value in ticks. The defaults are fetch 3, decode 2, execute 2, data memory 4 and write-back 2. A duration of zero is refused at elaboration.
- R3: `instClass` selects the path. 2'b00 (register ALU op) visits fetch, decode, execute and write-back and skips data memory. 2'b01 (load) visits all five stages. 2'b10 (store) ends after data memory. 2'b11 (branch) ends after execute.
- R4: `stageEn` is a one-tick pulse on bit i, raised only on the final tick of stage i, and it is zero on every other tick.
- R5: `done` is high for exactly one tick, the last tick of the final visited stage. With default durations the instruction lengths are 9 ticks (ALU op), 13 (load), 11 (store) and 7 (branch).
- R6: `tickCount` equals 1 on the first fetch tick and rises by one every tick of the instruction. It therefore equals the total latency on the done tick, and it holds that total while idle.
- R7: A start seen at a clock edge while idle gives the first fetch tick in the next cycle. The class is captured at that same edge.
- R8: Start and class are ignored while an instruction runs, except on its done tick. A start there launches a new fetch in the very next cycle with the new class, and `tickCount` restarts at 1.
- R9: A synchronous active-high `rst` returns the block to idle: zero stage, enable and done outputs and a `tickCount` of 0, even if it arrives in the middle of an instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast base clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin an instruction |
| instClass | input | 2 | Instruction class, sampled when start is accepted |
| stageOneHot | output | 5 | Current stage, one-hot |
| stageEn | output | 5 | Per-stage latch pulse on a stage's last tick |
| done | output | 1 | Instruction-complete strobe |
| tickCount | output | TW (4 by default) | Ticks used by the current or last instruction |

## Verification
A start accepted at clock edge E shows up first in the tick after E. From there the bench predicts every later output tick by tick, using only the class and the duration list. Stage, enable, done and count are all combinational or single-register outputs of the current tick, so the bench samples each of them at the falling edge inside the tick it expects. It changes the inputs straight after sampling, so a new drive lands on the edge that closes the tick just checked. For a start held through the done tick, the next fetch is due one tick after done. After a reset edge, the idle outputs are due at the next falling edge.

// File: rtl/mc_seq_pkg.sv
package mc_seq_pkg;

  localparam int NUM_STAGES = 5;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_FETCH  = 3'd1,
    ST_DECODE = 3'd2,
    ST_EXEC   = 3'd3,
    ST_MEM    = 3'd4,
    ST_WB     = 3'd5
  } stage_e;

  typedef enum logic [1:0] {
    CLS_ALU    = 2'b00,
    CLS_LOAD   = 2'b01,
    CLS_STORE  = 2'b10,
    CLS_BRANCH = 2'b11
  } iclass_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic   loadDwell;    // reload dwell counter for loadSel
    stage_e loadSel;      // stage whose duration is loaded
    logic   decDwell;     // count the dwell down
    logic   countUp;      // bump the tick total
    logic   restartTotal; // new instruction accepted
  } seq_strobe_t;

endpackage

// File: rtl/mc_seq_dp.sv
module mc_seq_dp
  import mc_seq_pkg::*;
#(
  parameter int unsigned DUR_FETCH  = 3,
  parameter int unsigned DUR_DECODE = 2,
  parameter int unsigned DUR_EXEC   = 2,
  parameter int unsigned DUR_MEM    = 4,
  parameter int unsigned DUR_WB     = 2,
  parameter int unsigned DW         = 3,
  parameter int unsigned TW         = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  seq_strobe_t   strb,
  output logic          lastTick,
  output logic [TW-1:0] tickCount
);

  logic [DW-1:0] dwell;
  logic [DW-1:0] reloadVal;

  always_comb begin
    unique case (strb.loadSel)
      ST_FETCH:  reloadVal = DW'(DUR_FETCH - 1);
      ST_DECODE: reloadVal = DW'(DUR_DECODE - 1);
      ST_EXEC:   reloadVal = DW'(DUR_EXEC - 1);
      ST_MEM:    reloadVal = DW'(DUR_MEM - 1);
      ST_WB:     reloadVal = DW'(DUR_WB - 1);
      default:   reloadVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dwell <= '0;
    end else if (strb.loadDwell) begin
      dwell <= reloadVal;
    end else if (strb.decDwell && dwell != '0) begin
      dwell <= dwell - 1'b1;
    end
  end

  assign lastTick = (dwell == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      tickCount <= '0;
    end else if (strb.restartTotal) begin
      tickCount <= TW'(1);
    end else if (strb.countUp) begin
      tickCount <= tickCount + 1'b1;
    end
  end

  // R6: a running instruction's count grows by one each tick
  assert_count_step_R6: assert property (@(posedge clk) disable iff (rst)
    (strb.countUp && !strb.restartTotal) |=> tickCount == $past(tickCount) + 1'b1);

  // R6: a fresh instruction starts counting at one
  assert_count_restart_R6: assert property (@(posedge clk) disable iff (rst)
    strb.restartTotal |=> tickCount == TW'(1));

endmodule

// File: rtl/mc_seq_ctrl.sv
module mc_seq_ctrl
  import mc_seq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [1:0]            instClass,
  input  logic                  lastTick,
  output seq_strobe_t           strb,
  output logic [NUM_STAGES-1:0] stageOneHot,
  output logic [NUM_STAGES-1:0] stageEn,
  output logic                  done
);

  stage_e  stage, nextStage, succ;
  iclass_e cls;
  logic    active, stageEnd, isFinal, accept;

  assign active   = (stage != ST_IDLE);
  assign stageEnd = active && lastTick;

  always_comb begin
    unique case (stage)
      ST_EXEC: isFinal = (cls == CLS_BRANCH);
      ST_MEM:  isFinal = (cls == CLS_STORE);
      ST_WB:   isFinal = 1'b1;
      default: isFinal = 1'b0;
    endcase
  end

  always_comb begin
    unique case (stage)
      ST_FETCH:  succ = ST_DECODE;
      ST_DECODE: succ = ST_EXEC;
      ST_EXEC:   succ = (cls == CLS_ALU) ? ST_WB : ST_MEM;
      ST_MEM:    succ = ST_WB;
      default:   succ = ST_IDLE;
    endcase
  end

  assign done   = stageEnd && isFinal;
  assign accept = start && (!active || done);

  always_comb begin
    nextStage = stage;
    if (!active) begin
      if (start) nextStage = ST_FETCH;
    end else if (stageEnd) begin
      if (isFinal) nextStage = start ? ST_FETCH : ST_IDLE;
      else         nextStage = succ;
    end
  end

  always_comb begin
    strb.loadDwell    = (nextStage != ST_IDLE) && (accept || nextStage != stage);
    strb.loadSel      = nextStage;
    strb.decDwell     = active && !lastTick;
    strb.countUp      = active && !done;
    strb.restartTotal = accept;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage <= ST_IDLE;
      cls   <= CLS_ALU;
    end else begin
      stage <= nextStage;
      if (accept) cls <= iclass_e'(instClass);
    end
  end

  for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stageOut
    assign stageOneHot[i] = (stage == stage_e'(i + 1));
    assign stageEn[i]     = stageOneHot[i] && lastTick;
  end

  // R1: at most one stage is shown
  assert_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stageOneHot));

  // R2: the stage holds until its dwell runs out
  assert_dwell_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (active && !lastTick) |=> stage == $past(stage));

  // R4: an enable pulse always closes its stage
  assert_en_closes_R4: assert property (@(posedge clk) disable iff (rst)
    (|stageEn) |=> stageOneHot != $past(stageOneHot));

  // R5: done never lasts two ticks
  assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7: start while idle goes to fetch
  assert_idle_start_R7: assert property (@(posedge clk) disable iff (rst)
    (!active && start) |=> stage == ST_FETCH);

  // R8: start on the done tick goes straight to fetch
  assert_chain_R8: assert property (@(posedge clk) disable iff (rst)
    (done && start) |=> stage == ST_FETCH);

endmodule

// File: rtl/mc_stage_seq.sv
module mc_stage_seq
  import mc_seq_pkg::*;
#(
  parameter int unsigned DUR_FETCH  = 3,
  parameter int unsigned DUR_DECODE = 2,
  parameter int unsigned DUR_EXEC   = 2,
  parameter int unsigned DUR_MEM    = 4,
  parameter int unsigned DUR_WB     = 2,
  localparam int unsigned MAX_A   = (DUR_FETCH > DUR_DECODE) ? DUR_FETCH : DUR_DECODE,
  localparam int unsigned MAX_B   = (DUR_EXEC > DUR_MEM) ? DUR_EXEC : DUR_MEM,
  localparam int unsigned MAX_AB  = (MAX_A > MAX_B) ? MAX_A : MAX_B,
  localparam int unsigned MAX_DUR = (MAX_AB > DUR_WB) ? MAX_AB : DUR_WB,
  localparam int unsigned SUM_DUR = DUR_FETCH + DUR_DECODE + DUR_EXEC + DUR_MEM + DUR_WB,
  localparam int unsigned DW      = (MAX_DUR > 1) ? $clog2(MAX_DUR) : 1,
  localparam int unsigned TW      = $clog2(SUM_DUR + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [1:0]            instClass,
  output logic [NUM_STAGES-1:0] stageOneHot,
  output logic [NUM_STAGES-1:0] stageEn,
  output logic                  done,
  output logic [TW-1:0]         tickCount
);

  if (DUR_FETCH == 0 || DUR_DECODE == 0 || DUR_EXEC == 0 ||
      DUR_MEM == 0 || DUR_WB == 0) begin : g_badDur
    $error("every stage duration must be at least one tick");
  end

  seq_strobe_t strb;
  logic        lastTick;

  mc_seq_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .instClass   (instClass),
    .lastTick    (lastTick),
    .strb        (strb),
    .stageOneHot (stageOneHot),
    .stageEn     (stageEn),
    .done        (done)
  );

  mc_seq_dp #(
    .DUR_FETCH  (DUR_FETCH),
    .DUR_DECODE (DUR_DECODE),
    .DUR_EXEC   (DUR_EXEC),
    .DUR_MEM    (DUR_MEM),
    .DUR_WB     (DUR_WB),
    .DW         (DW),
    .TW         (TW)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .lastTick  (lastTick),
    .tickCount (tickCount)
  );

  // R5: no instruction finishes faster than fetch+decode+execute
  assert_min_latency_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> tickCount >= TW'(DUR_FETCH + DUR_DECODE + DUR_EXEC));

  // R1: done comes only while some stage is shown
  assert_done_in_stage_R1: assert property (@(posedge clk) disable iff (rst)
    done |-> stageOneHot != '0);

endmodule

// File: tb/mc_stage_seq_tb.sv
module mc_stage_seq_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [1:0] instClass = 2'b00;
  logic [4:0] stageOneHot, stageEn;
  logic       done;
  logic [3:0] tickCount;

  int nChecks = 0;
  int nFails  = 0;
  int durs [5] = '{3, 2, 2, 4, 2};

  always #2 clk = ~clk;

  mc_stage_seq u_dut (
    .clk(clk), .rst(rst), .start(start), .instClass(instClass),
    .stageOneHot(stageOneHot), .stageEn(stageEn), .done(done), .tickCount(tickCount)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic checkIdle(input string req, input int heldCount);
    check(stageOneHot == 5'd0, req, "idle stage", stageOneHot, 0);
    check(stageEn == 5'd0, req, "idle enable", stageEn, 0);
    check(done == 1'b0, req, "idle done", done, 0);
    check(tickCount == heldCount[3:0], req, "idle count", tickCount, heldCount);
  endtask

  // start accepted at the next rising edge
  task automatic issue(input logic [1:0] cls);
    @(negedge clk);
    start = 1'b1;
    instClass = cls;
  endtask

  // follows one instruction tick by tick; fetch tick 1 is the next falling edge
  task automatic traceInstr(input logic [1:0] cls, input bit noisy, input bit keepStart,
                            input logic [1:0] nextCls, input string req);
    bit visit [5];
    int lastS;
    int t = 0;
    visit[0] = 1; visit[1] = 1; visit[2] = 1;
    visit[3] = (cls == 2'b01) || (cls == 2'b10);
    visit[4] = (cls == 2'b00) || (cls == 2'b01);
    lastS = (cls == 2'b11) ? 2 : (cls == 2'b10) ? 3 : 4;
    for (int s = 0; s < 5; s++) begin
      if (visit[s]) begin
        for (int d = 0; d < durs[s]; d++) begin
          bit endTick;
          bit fin;
          endTick = (d == durs[s] - 1);
          fin = endTick && (s == lastS);
          t++;
          @(negedge clk);
          check(stageOneHot == 5'(1 << s), req, "stage", stageOneHot, 1 << s);
          check(stageEn == (endTick ? 5'(1 << s) : 5'd0), req, "enable", stageEn,
                endTick ? (1 << s) : 0);
          check(done == fin, req, "done", done, fin);
          check(tickCount == t[3:0], req, "count", tickCount, t);
          if (fin) begin
            start = keepStart;
            instClass = nextCls;
          end else begin
            start = keepStart | noisy;
            instClass = ~cls;
          end
        end
      end
    end
  endtask

  task automatic testReset;
    // R9: outputs quiet after reset even with start held during it
    rst = 1'b1; start = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkIdle("R9", 0);
    rst = 1'b0; start = 1'b0;
  endtask

  task automatic testAluOp;
    // R1 R2 R3 R5 R6 R7: ALU op takes 3+2+2+2 = 9 ticks
    issue(2'b00);
    traceInstr(2'b00, 1'b0, 1'b0, 2'b00, "R3");
    @(negedge clk);
    checkIdle("R6", 9);
    @(negedge clk);
    checkIdle("R6", 9);
  endtask

  task automatic testClasses;
    // R3 R5: load 13, store 11, branch 7
    issue(2'b01);
    traceInstr(2'b01, 1'b0, 1'b0, 2'b00, "R3");
    @(negedge clk); checkIdle("R5", 13);
    issue(2'b10);
    traceInstr(2'b10, 1'b0, 1'b0, 2'b00, "R3");
    @(negedge clk); checkIdle("R5", 11);
    issue(2'b11);
    traceInstr(2'b11, 1'b0, 1'b0, 2'b00, "R2");
    @(negedge clk); checkIdle("R5", 7);
  endtask

  task automatic testNoisy;
    // R8: start and class toggling mid-instruction change nothing
    issue(2'b00);
    traceInstr(2'b00, 1'b1, 1'b0, 2'b00, "R8");
    @(negedge clk); checkIdle("R8", 9);
  endtask

  task automatic testChain;
    // R8: start held on done launches the next fetch without a gap
    issue(2'b10);
    traceInstr(2'b10, 1'b0, 1'b1, 2'b11, "R8");
    traceInstr(2'b11, 1'b0, 1'b1, 2'b01, "R8");
    traceInstr(2'b01, 1'b0, 1'b0, 2'b00, "R8");
    @(negedge clk); checkIdle("R8", 13);
  endtask

  task automatic testMidReset;
    // R9: reset inside an instruction
    issue(2'b01);
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    checkIdle("R9", 0);
    rst = 1'b0;
    @(negedge clk);
    checkIdle("R9", 0);
    // R7: next start after reset behaves normally
    issue(2'b11);
    traceInstr(2'b11, 1'b0, 1'b0, 2'b00, "R7");
  endtask

  task automatic finishRun;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    testReset();
    testAluOp();
    testClasses();
    testNoisy();
    testChain();
    testMidReset();
    repeat (2) @(negedge clk);
    finishRun();
  end

  initial begin
    #(4 * 50000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected finish");
    finishRun();
  end

endmodule